// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block is the receive front end of a two-wire (I2C) slave. It brings the raw clock and data lines into the system clock domain through a synchroniser and passes each one through a glitch filter. It then turns the filtered levels into one-cycle event pulses that a protocol engine uses to shift bits in and out: a start condition (with a qualifier that marks a repeated start), a stop condition, a clock rising edge with the data bit sampled at that edge, and a clock falling edge.

While the device runs its internal programming cycle, the engine raises a busy input. Every bus event is then dropped, so the bus is simply not seen for that time. The glitch filter width is a parameter counted in system clocks. Any level change that does not hold for that many clocks never reaches the event logic.

Top module: `bus_cond_detect`

## Requirements
- R1: During and after a synchronous reset, all event outputs and `xfer_active` are 0, and both filtered lines read as idle high.
- R2: On either line, a raw level excursion that lasts fewer than FILT_CLKS system clocks produces no event. An excursion of FILT_CLKS clocks or longer is accepted as a real level change.
- R3: Every event output is high for exactly one clock. It appears FILT_CLKS+3 rising clock edges after the raw input change that causes it (two synchroniser stages, the filter window and one output register).
- R4: A falling data line while the clock line is filtered high, both in the previous and in the current cycle, gives one `ev_start` pulse and sets `xfer_active`.
- R5: A rising data line while the clock line is filtered high in both cycles gives one `ev_stop` pulse and clears `xfer_active`.
- R6: A rising edge of the filtered clock gives one `ev_rise` pulse. `ev_bit` carries the filtered data level in that same cycle. Across a byte, the bits arrive most significant first in the order they were driven.
- R7: A falling edge of the filtered clock gives one `ev_fall` pulse.
- R8: At most one of `ev_start`, `ev_stop`, `ev_rise` and `ev_fall` is high in any cycle. If the data line changes in the same cycle as a clock edge, only the clock edge is reported and no start or stop is reported.
- R9: While `prog_busy` is high, no event is reported and `xfer_active` does not change. Conditions that occur under busy are dropped: no event for them appears after busy falls.
- R10: A start that is reported while `xfer_active` is already 1 raises `ev_restart` in the same cycle as `ev_start`. `ev_restart` is never high without `ev_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Raw bus clock line level |
| sda_raw | input | 1 | Raw bus data line level |
| prog_busy | input | 1 | High while the internal programming cycle runs; masks all events |
| ev_start | output | 1 | One-cycle start condition pulse |
| ev_restart | output | 1 | High with `ev_start` when the start arrives inside a transfer |
| ev_stop | output | 1 | One-cycle stop condition pulse |
| ev_rise | output | 1 | One-cycle clock rising edge pulse |
| ev_bit | output | 1 | Data level sampled at the clock rising edge, valid with `ev_rise` |
| ev_fall | output | 1 | One-cycle clock falling edge pulse |
| xfer_active | output | 1 | Set by a start, cleared by a stop |

## Verification
The hardest case to reach from the ports is the exact limit of the glitch filter. An excursion one clock shorter than the window has to vanish, and one of exactly the window length has to pass. The stimulus therefore drives the raw lines from the falling clock edge and sweeps the excursion length from one clock to two beyond the window on each line. A pair of simultaneous clock and data changes checks the tie-break between a clock edge and a start. The byte path is covered by sending all 256 data values inside one transfer.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;

  typedef struct packed {
    logic start;
    logic restart;
    logic stop;
    logic rise;
    logic bit_val;
    logic fall;
  } bus_ev_t;
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '1;
          else     stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '1;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/bcd_filter.sv
module bcd_filter #(
  parameter int unsigned FILT_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic level_out
);
  localparam int unsigned CW = (FILT_CLKS > 1) ? $clog2(FILT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CLKS - 1);

  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_q <= 1'b1;
    end else if (level_in == level_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      level_q <= level_in;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_out = level_q;

  // The filtered level only moves to the value the input held in the cycle before.
  assert_follow_input_R2: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(level_in) == level_q));

  // The run counter never passes the window.
  assert_window_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run_q <= LAST);
endmodule

// File: rtl/bcd_events.sv
module bcd_events
  import bcd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_f,
  input  logic    sda_f,
  input  logic    busy,
  output bus_ev_t ev,
  output logic    active
);
  logic scl_p, sda_p;
  logic hold_hi, c_start, c_stop, c_rise, c_fall;
  bus_ev_t ev_q;
  logic active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  always_comb begin
    hold_hi = scl_f & scl_p;
    c_rise  = scl_f & ~scl_p;
    c_fall  = ~scl_f & scl_p;
    c_start = hold_hi & sda_p & ~sda_f;
    c_stop  = hold_hi & ~sda_p & sda_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q     <= '0;
      active_q <= 1'b0;
    end else begin
      ev_q <= '0;
      if (!busy) begin
        if (c_start) begin
          ev_q.start   <= 1'b1;
          ev_q.restart <= active_q;
          active_q     <= 1'b1;
        end else if (c_stop) begin
          ev_q.stop <= 1'b1;
          active_q  <= 1'b0;
        end else if (c_rise) begin
          ev_q.rise    <= 1'b1;
          ev_q.bit_val <= sda_f;
        end else if (c_fall) begin
          ev_q.fall <= 1'b1;
        end
      end
    end
  end

  assign ev     = ev_q;
  assign active = active_q;

  assert_one_event_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_q.start, ev_q.stop, ev_q.rise, ev_q.fall}));

  assert_busy_mask_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(ev_q.start || ev_q.stop || ev_q.rise || ev_q.fall));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(active_q));

  assert_restart_qual_R10: assert property (@(posedge clk) disable iff (rst)
    ev_q.restart |-> ev_q.start);

  assert_stop_clears_R5: assert property (@(posedge clk) disable iff (rst)
    ev_q.stop |-> !active_q);

  assert_active_set_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> ev_q.start);

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    ev_q.rise |=> !ev_q.rise);
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
  import bcd_pkg::*;
#(
  parameter int unsigned FILT_CLKS   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  input  logic prog_busy,
  output logic ev_start,
  output logic ev_restart,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_bit,
  output logic ev_fall,
  output logic xfer_active
);
  logic [NUM_LINES-1:0] raw_v, sync_v, filt_v;
  bus_ev_t ev;

  assign raw_v[LINE_SCL] = scl_raw;
  assign raw_v[LINE_SDA] = sda_raw;

  bcd_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (raw_v),
    .dout(sync_v)
  );

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      bcd_filter #(.FILT_CLKS(FILT_CLKS)) filt_i (
        .clk      (clk),
        .rst      (rst),
        .level_in (sync_v[l]),
        .level_out(filt_v[l])
      );
    end
  endgenerate

  bcd_events ev_i (
    .clk   (clk),
    .rst   (rst),
    .scl_f (filt_v[LINE_SCL]),
    .sda_f (filt_v[LINE_SDA]),
    .busy  (prog_busy),
    .ev    (ev),
    .active(xfer_active)
  );

  assign ev_start   = ev.start;
  assign ev_restart = ev.restart;
  assign ev_stop    = ev.stop;
  assign ev_rise    = ev.rise;
  assign ev_bit     = ev.bit_val;
  assign ev_fall    = ev.fall;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !(ev_start || ev_stop || ev_rise || ev_fall || xfer_active));
endmodule

// File: tb/bus_cond_detect_tb_top.sv
module bus_cond_detect_tb_top;
  localparam int F = 3;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, busy = 1'b0;
  logic ev_start, ev_restart, ev_stop, ev_rise, ev_bit, ev_fall, xfer_active;

  int n_run = 0, n_fail = 0;
  int c_start = 0, c_rest = 0, c_stop = 0, c_rise = 0, c_fall = 0, c_multi = 0;
  logic [7:0] shreg = '0;
  logic last_bit = 1'b0;

  always #5 clk = ~clk;

  bus_cond_detect #(.FILT_CLKS(F)) dut_i (
    .clk(clk), .rst(rst), .scl_raw(scl), .sda_raw(sda), .prog_busy(busy),
    .ev_start(ev_start), .ev_restart(ev_restart), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_bit(ev_bit), .ev_fall(ev_fall),
    .xfer_active(xfer_active)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (ev_start) c_start++;
      if (ev_restart) c_rest++;
      if (ev_stop) c_stop++;
      if (ev_fall) c_fall++;
      if (ev_rise) begin
        c_rise++;
        last_bit = ev_bit;
        shreg = {shreg[6:0], ev_bit};
      end
      if ((32'(ev_start) + 32'(ev_stop) + 32'(ev_rise) + 32'(ev_fall)) > 1) c_multi++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    c_start = 0; c_rest = 0; c_stop = 0; c_rise = 0; c_fall = 0;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda = b; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(H);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    wt(4);
    // R1: reset state
    chk(!(ev_start | ev_stop | ev_rise | ev_fall | xfer_active), "R1 reset outputs", 0, 0);
    rst = 1'b0;
    wt(20);
    chk(c_start + c_stop + c_rise + c_fall == 0, "R1 idle after reset", c_start + c_stop, 0);

    // R3 + R4: start latency
    clr();
    sda = 1'b0;
    lat = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (ev_start && lat == 0) lat = i;
    end
    chk(lat == F + 3, "R3 start latency", lat, F + 3);
    chk(c_start == 1, "R4 single start pulse", c_start, 1);
    chk(xfer_active == 1'b1, "R4 active set", int'(xfer_active), 1);
    chk(c_rest == 0, "R10 first start not repeated", c_rest, 0);
    sda = 1'b1; wt(20);
    chk(c_stop == 1, "R5 stop pulse", c_stop, 1);
    chk(xfer_active == 1'b0, "R5 active cleared", int'(xfer_active), 0);

    // R2: glitch sweep on data line (clock high)
    for (int w = 1; w <= F + 2; w++) begin
      clr();
      sda = 1'b0; wt(w); sda = 1'b1; wt(20);
      chk(c_start == ((w >= F) ? 1 : 0), "R2 sda glitch start", c_start, (w >= F) ? 1 : 0);
      chk(c_stop == ((w >= F) ? 1 : 0), "R2 sda glitch stop", c_stop, (w >= F) ? 1 : 0);
    end

    // R2 + R6 + R7: glitch sweep on clock line (data high)
    for (int w = 1; w <= F + 2; w++) begin
      clr();
      scl = 1'b0; wt(w); scl = 1'b1; wt(20);
      chk(c_fall == ((w >= F) ? 1 : 0), "R2 R7 scl glitch fall", c_fall, (w >= F) ? 1 : 0);
      chk(c_rise == ((w >= F) ? 1 : 0), "R2 R6 scl glitch rise", c_rise, (w >= F) ? 1 : 0);
      chk(c_start + c_stop == 0, "R2 scl glitch no start/stop", c_start + c_stop, 0);
    end

    // R9: everything dropped under busy
    clr();
    busy = 1'b1; wt(2);
    sda = 1'b0; wt(H); scl = 1'b0; wt(H); scl = 1'b1; wt(H); sda = 1'b1; wt(H);
    wt(10);
    chk(c_start + c_stop + c_rise + c_fall == 0, "R9 masked while busy",
        c_start + c_stop + c_rise + c_fall, 0);
    chk(xfer_active == 1'b0, "R9 active unchanged", int'(xfer_active), 0);
    busy = 1'b0; wt(20);
    chk(c_start + c_stop + c_rise + c_fall == 0, "R9 nothing after busy",
        c_start + c_stop + c_rise + c_fall, 0);

    // R4: start after busy, then R8 simultaneous clock rise and data fall
    clr();
    sda = 1'b0; wt(H);
    chk(c_start == 1 && c_rest == 0, "R4 start after busy", c_start, 1);
    scl = 1'b0; wt(H); sda = 1'b1; wt(H);
    clr();
    scl = 1'b1; sda = 1'b0; wt(H);
    chk(c_rise == 1 && c_start == 0, "R8 clock edge wins", c_start, 0);
    chk(last_bit == 1'b0, "R6 bit at simultaneous edge", int'(last_bit), 0);

    // R10: repeated start inside transfer
    scl = 1'b0; wt(H); sda = 1'b1; wt(H); scl = 1'b1; wt(H);
    clr();
    sda = 1'b0; wt(H);
    chk(c_start == 1, "R10 repeated start pulse", c_start, 1);
    chk(c_rest == 1, "R10 repeated start flagged", c_rest, 1);
    scl = 1'b0; wt(H);

    // R6: all byte values, msb first
    for (int v = 0; v < 256; v++) begin
      clr();
      for (int b = 7; b >= 0; b--) send_bit(v[b]);
      chk(shreg == v[7:0], "R6 byte value", int'(shreg), v);
      chk(c_rise == 8 && c_fall == 8, "R7 edges per byte", c_fall, 8);
    end
    chk(c_multi == 0, "R8 one event per cycle", c_multi, 0);

    // R5: end transfer
    clr();
    sda = 1'b0; wt(H); scl = 1'b1; wt(H); sda = 1'b1; wt(H);
    chk(c_stop == 1 && xfer_active == 1'b0, "R5 final stop", c_stop, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule